// File: doc/BRIEF.md
# Pipelined Add-Plus-Constant Unit

This block takes two unsigned operands of a configurable width and returns their sum plus a fixed constant, keeping only as many result bits as the operands have. The arithmetic is done by two rows of full adders. The first row adds the two operands and ripples its carry upward. The second row adds the constant's bit pattern to the partial sum and ripples its own carry. The default configuration is 3-bit operands with a constant of five.

The two rows are cut into pipeline stages so that no path between registers passes through more than one full adder. As a result, the clock period is set by a single full-adder delay. Operand bits that a later stage still needs, the partial sums and the carries all travel down the pipeline together. Each operand pair therefore meets only its own intermediate values. A new pair can be presented on every clock, and results emerge in order, one per clock, once the pipeline has filled.

Top module: `cadd_pipe`

## Requirements
- R1: Once the pipeline has filled, `sum` equals (`op_a` + `op_b` + OFFSET) mod 2^WIDTH for the operand pair presented a fixed number of cycles earlier. The defaults are WIDTH = 3 and OFFSET = 5.
- R2: An operand pair sampled at one rising edge appears on `sum` right after the WIDTH-th rising edge that follows it. The latency is WIDTH+1 edges counted from the capture edge, so 4 edges for the default width.
- R3: A new operand pair is accepted at every rising edge with no idle cycles. Results leave in the same order as the operands arrived, one per cycle, and hold no unknown bits.
- R4: Reset is synchronous and active low. A rising edge with `rst_n` low clears every pipeline register, so `sum` reads 0 in the cycle after that edge. Operands still in flight at that edge are dropped.
- R5: A carry out of the most significant bit in either row is discarded. For example, 7 + 7 + 5 with WIDTH = 3 yields 3.
- R6: WIDTH and OFFSET are parameters. An instance with WIDTH = 4 and OFFSET = 9 produces (`op_a` + `op_b` + 9) mod 16 after a latency of 5 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH | Registered (op_a + op_b + OFFSET) mod 2^WIDTH |

## Verification
The assertions check four things on every cycle once the pipeline has filled: the arithmetic against a delay line of the operands, the low sum bit, the absence of unknown output bits, and the zeroed output after a reset edge. Three behaviours are shown only by the bench's scenarios, because a per-cycle property does not capture them. The first is exact ordering over every operand combination of both configurations. The second is that in-flight operands are dropped by a reset in mid-stream. The third is the exact cycle in which a single changed operand pair shows up amid a steady stream.

// File: rtl/cadd_pkg.sv
// Package cadd_pkg
// Holds the full-adder result type and the evaluation function that the
// adder cells share. It is purely combinational and holds no state.
package cadd_pkg;

    // Result of one full-adder evaluation.
    typedef struct packed {
        logic s;
        logic co;
    } fa_res_t;

    // Evaluates one bit of a binary addition with carry.
    function automatic fa_res_t full_add(input logic x, input logic y, input logic ci);
        fa_res_t r;
        r.s  = x ^ y ^ ci;
        r.co = (x & y) | (x & ci) | (y & ci);
        return r;
    endfunction

endpackage

// File: rtl/cadd_fa.sv
// Module cadd_fa
// A single full-adder cell, built on the package function.
// Assumes: its inputs settle within one clock period. It holds no state.
module cadd_fa
    import cadd_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);

    fa_res_t res;

    // Combine the three input bits into a sum bit and a carry bit.
    always_comb begin
        res = full_add(x, y, ci);
        s   = res.s;
        co  = res.co;
    end

endmodule

// File: rtl/cadd_stage.sv
// Module cadd_stage
// One pipeline stage of the two-row adder.
// Stage IDX evaluates operand-row bit IDX when IDX < WIDTH, and constant-row
// bit IDX-1 when IDX >= 1. It then registers every vector it passes on.
// Assumes: its inputs come from stage IDX-1, or from the ports for IDX = 0.
// At most one full adder lies on any input-to-register path of a stage.
module cadd_stage #(
    parameter int WIDTH  = 3,
    parameter int IDX    = 0,
    parameter int OFFSET = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] s1_i,
    input  logic [WIDTH-1:0] f_i,
    input  logic             c1_i,
    input  logic             c2_i,
    output logic [WIDTH-1:0] a_o,
    output logic [WIDTH-1:0] b_o,
    output logic [WIDTH-1:0] s1_o,
    output logic [WIDTH-1:0] f_o,
    output logic             c1_o,
    output logic             c2_o
);

    localparam logic [WIDTH-1:0] KBITS = WIDTH'(OFFSET);

    logic [WIDTH-1:0] s1_n;
    logic [WIDTH-1:0] f_n;
    logic             c1_n;
    logic             c2_n;

    generate
        if (IDX < WIDTH) begin : g_row1
            logic r1_s;
            cadd_fa u_fa1 (
                .x  (a_i[IDX]),
                .y  (b_i[IDX]),
                .ci (c1_i),
                .s  (r1_s),
                .co (c1_n)
            );
            // Place this stage's operand-row sum bit into the partial-sum vector.
            always_comb begin
                s1_n      = s1_i;
                s1_n[IDX] = r1_s;
            end
        end else begin : g_row1_idle
            // The operand row is finished, so pass the partial sum on unchanged.
            always_comb begin
                s1_n = s1_i;
                c1_n = 1'b0;
            end
        end

        if (IDX >= 1) begin : g_row2
            localparam int J = IDX - 1;
            logic r2_s;
            cadd_fa u_fa2 (
                .x  (s1_i[J]),
                .y  (KBITS[J]),
                .ci (c2_i),
                .s  (r2_s),
                .co (c2_n)
            );
            // Place this stage's result bit into the output vector.
            always_comb begin
                f_n    = f_i;
                f_n[J] = r2_s;
            end
        end else begin : g_row2_idle
            // The constant row has not started yet, so pass its state on unchanged.
            always_comb begin
                f_n  = f_i;
                c2_n = c2_i;
            end
        end
    endgenerate

    // Stage register: cleared by a synchronous reset, otherwise loaded every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_o  <= '0;
            b_o  <= '0;
            s1_o <= '0;
            f_o  <= '0;
            c1_o <= 1'b0;
            c2_o <= 1'b0;
        end else begin
            a_o  <= a_i;
            b_o  <= b_i;
            s1_o <= s1_n;
            f_o  <= f_n;
            c1_o <= c1_n;
            c2_o <= c2_n;
        end
    end

endmodule

// File: rtl/cadd_pipe.sv
// Module cadd_pipe (top)
// Computes (op_a + op_b + OFFSET) mod 2^WIDTH in WIDTH+1 pipeline stages.
// Each stage holds one full adder of each row.
// Assumes: a new operand pair on every clock. There is no stall and no handshake.
// Reset is synchronous and active low.
module cadd_pipe #(
    parameter int WIDTH  = 3,
    parameter int OFFSET = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum
);

    localparam int STAGES = WIDTH + 1;

    logic [WIDTH-1:0] a_p  [STAGES+1];
    logic [WIDTH-1:0] b_p  [STAGES+1];
    logic [WIDTH-1:0] s1_p [STAGES+1];
    logic [WIDTH-1:0] f_p  [STAGES+1];
    logic             c1_p [STAGES+1];
    logic             c2_p [STAGES+1];

    // Feed the first stage from the ports, with empty partial sums and carries.
    always_comb begin
        a_p[0]  = op_a;
        b_p[0]  = op_b;
        s1_p[0] = '0;
        f_p[0]  = '0;
        c1_p[0] = 1'b0;
        c2_p[0] = 1'b0;
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            cadd_stage #(
                .WIDTH  (WIDTH),
                .IDX    (s),
                .OFFSET (OFFSET)
            ) u_stage (
                .clk  (clk),
                .rst_n(rst_n),
                .a_i  (a_p[s]),
                .b_i  (b_p[s]),
                .s1_i (s1_p[s]),
                .f_i  (f_p[s]),
                .c1_i (c1_p[s]),
                .c2_i (c2_p[s]),
                .a_o  (a_p[s+1]),
                .b_o  (b_p[s+1]),
                .s1_o (s1_p[s+1]),
                .f_o  (f_p[s+1]),
                .c1_o (c1_p[s+1]),
                .c2_o (c2_p[s+1])
            );
        end
    endgenerate

    // The last stage's result vector drives the output directly from its register.
    assign sum = f_p[STAGES];

endmodule

// File: rtl/cadd_pipe_chk.sv
// Module cadd_pipe_chk
// Checker bound to cadd_pipe. It delays the operands by the pipeline latency
// and compares the output with them. It also checks the output after a reset.
// Assumes: the bench starts with rst_n low.
module cadd_pipe_chk #(
    parameter int WIDTH  = 3,
    parameter int OFFSET = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] sum
);

    localparam int LAT = WIDTH + 1;
    localparam logic [WIDTH-1:0] KBITS = WIDTH'(OFFSET);

    logic [WIDTH-1:0] a_d [LAT];
    logic [WIDTH-1:0] b_d [LAT];
    logic [WIDTH-1:0] exp_sum;
    int               fill;
    logic             was_rst;

    // Operand delay line, fill counter since reset, and a flag for the previous reset edge.
    always_ff @(posedge clk) begin
        a_d[0]  <= op_a;
        b_d[0]  <= op_b;
        for (int i = 1; i < LAT; i++) begin
            a_d[i] <= a_d[i-1];
            b_d[i] <= b_d[i-1];
        end
        was_rst <= !rst_n;
        if (!rst_n)
            fill <= 0;
        else if (fill < LAT)
            fill <= fill + 1;
    end

    // Expected result for the operand pair that is leaving the pipeline now.
    always_comb exp_sum = a_d[LAT-1] + b_d[LAT-1] + KBITS;

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> sum == '0);  // R4
    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == LAT) |-> sum == exp_sum);  // R1
    AST_LSB_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == LAT) |-> sum[0] == (a_d[LAT-1][0] ^ b_d[LAT-1][0] ^ KBITS[0]));  // R2
    AST_KNOWN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == LAT) |-> !$isunknown(sum));  // R3

endmodule

bind cadd_pipe cadd_pipe_chk #(.WIDTH(WIDTH), .OFFSET(OFFSET)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .op_a (op_a),
    .op_b (op_b),
    .sum  (sum)
);

// File: tb/tb_cadd_pipe.sv
`timescale 1ns/100ps
// Bench for cadd_pipe. A queue-based reference model is checked once per clock.
module tb_cadd_pipe;

    localparam int W1 = 3, K1 = 5, L1 = W1 + 1;
    localparam int W2 = 4, K2 = 9, L2 = W2 + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W1-1:0] a1 = '0, b1 = '0;
    logic [W1-1:0] sum1;
    logic [W2-1:0] a2 = '0, b2 = '0;
    logic [W2-1:0] sum2;
    int            checks = 0;
    int            errors = 0;

    always #2.5 clk = ~clk;

    cadd_pipe #(.WIDTH(W1), .OFFSET(K1)) dut (
        .clk(clk), .rst_n(rst_n), .op_a(a1), .op_b(b1), .sum(sum1));

    cadd_pipe #(.WIDTH(W2), .OFFSET(K2)) dut2 (
        .clk(clk), .rst_n(rst_n), .op_a(a2), .op_b(b2), .sum(sum2));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int q1[$];
        int q2[$];
        int e;
        repeat (3) @(negedge clk);
        chk("R4 reset clears sum", {29'd0, sum1}, 0);
        chk("R4 reset clears sum (dut2)", {28'd0, sum2}, 0);
        rst_n = 1'b1;

        // Every operand pair of the 3-bit unit, back to back, then zeros to drain.
        for (int i = 0; i < 64 + L1; i++) begin
            if (q1.size() == L1) begin
                e = q1.pop_front();
                if (e >= 8) chk("R5 wrap", {29'd0, sum1}, e % 8);
                else        chk("R1 R2 R3 stream", {29'd0, sum1}, e);
            end
            if (i < 64) begin
                a1 = W1'(i % 8);
                b1 = W1'(i / 8);
            end else begin
                a1 = '0;
                b1 = '0;
            end
            q1.push_back(int'(a1) + int'(b1) + K1);
            @(negedge clk);
        end

        // Reset in mid-stream: output zeroed, in-flight operands dropped.
        a1 = 3'd7; b1 = 3'd7; rst_n = 1'b0;
        @(negedge clk);
        chk("R4 mid-stream reset", {29'd0, sum1}, 0);
        rst_n = 1'b1; a1 = '0; b1 = '0;
        q1.delete();
        repeat (L1 + 1) @(negedge clk);
        chk("R4 R1 refill after reset", {29'd0, sum1}, 5);

        // One changed operand pair: it must appear exactly L1 edges later.
        a1 = 3'd7; b1 = 3'd7;
        @(negedge clk);
        a1 = '0; b1 = '0;
        for (int k = 1; k <= L1 + 1; k++) begin
            chk("R2 latency pulse", {29'd0, sum1}, (k == L1) ? 3 : 5);
            @(negedge clk);
        end

        // The wider configuration: all 256 pairs.
        for (int i = 0; i < 256 + L2; i++) begin
            if (q2.size() == L2) begin
                e = q2.pop_front();
                chk("R6 width 4 offset 9", {28'd0, sum2}, e % 16);
            end
            if (i < 256) begin
                a2 = W2'(i % 16);
                b2 = W2'(i / 16);
            end else begin
                a2 = '0;
                b2 = '0;
            end
            q2.push_back(int'(a2) + int'(b2) + K2);
            @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule